// File: doc/BRIEF.md
# Prioritized Fast/Normal Interrupt Controller

This block gathers 64 edge-triggered interrupt sources and drives two request lines toward a processor: a fast-interrupt line and a normal-interrupt line. Each source carries an enable bit and a 3-bit priority. A priority of 0 or 1 sends the source to the fast line. Values 2 to 7 send it to the normal line, and 7 is the weakest. Sources are split into two banks of 32. Source n sits in bank n/32 at bit n%32.

When a source input rises, the controller latches a pending bit. The bit goes into the fast or the normal status word of that bank, chosen by the source's priority in that cycle. Software reads the status words, then clears bits by writing ones. A read-only winner register names the strongest pending, enabled normal-line source. Software can then dispatch without scanning the banks.

The register port is a 32-bit word bus with byte addresses. A write is accepted in the cycle it is presented. Read data comes out of a register one cycle after the read strobe.

Top module: `intc_prio_router`

## Requirements
- R1: After reset, every status word, both enable words, the control word and the base word read 0. Every priority field reads 7 (so each priority word reads 0x77777777). The winner reads 0x7F, both request outputs are low and the read data is 0.
- R2: When source n goes from 0 to 1 between two clock samples, bit n%32 is set in bank n/32. It goes to the fast status word (0x00 for bank 0, 0x04 for bank 1) when the source's priority at that moment is 0 or 1. Otherwise it goes to the normal status word (0x08 for bank 0, 0x0C for bank 1). A source held high sets nothing further.
- R3: A write to a status word clears each pending bit whose written bit is 1 and leaves the bits written as 0 alone. When a new rising edge lands in the same cycle as a clear of that bit, the bit stays set.
- R4: The enable words at 0x18 (bank 0) and 0x1C (bank 1) are read/write. A source whose enable bit is 0 never drives a request output, but its pending bit is still captured. It drives its output as soon as the enable is set.
- R5: The fast output is high exactly while some enabled source has its fast-status bit set.
- R6: The normal output is high exactly while some enabled source has its normal-status bit set.
- R7: Priority word k sits at 0x30+4k and covers sources 8k to 8k+7. Source 8k+j keeps its priority in bits [4j+2:4j]. Bit 4j+3 is not stored and reads 0.
- R8: The word at 0x28 reads, in bits [6:0], the index of the enabled source with its normal-status bit set and the smallest current priority value. A tie goes to the lowest index. The word reads 0x7F when no such source exists. Upper bits read 0, writes to it are ignored, and fast-pending sources are not considered.
- R9: The control word at 0x20 and the base word at 0x24 store and return all 32 written bits.
- R10: Reads of any other byte address, including unaligned ones, return 0, and writes to them change no register.
- R11: A write takes effect at the clock edge that samples it. The read data register loads at the edge that samples a read strobe and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Interrupt source levels, one bit per source |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The edge-to-output properties assume that a source's rising edge, sampled at one clock edge, raises the matching request at the next edge. This holds only if no bus write lands in the same cycle, since such a write could clear the enable. The properties therefore exclude write cycles, and the directed stimulus holds each source change to a single cycle apart from bus writes, except in the one test that deliberately collides an edge with a clear. The stimulus never asserts the read and write strobes together. It changes sources and strobes on the falling clock edge, so every sample at the rising edge sees settled values.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // byte offsets whose values software depends on
   localparam int OFS_FIQ0 = 'h00;   // fast status, bank 1 at +4
   localparam int OFS_IRQ0 = 'h08;   // normal status, bank 1 at +4
   localparam int OFS_EN0  = 'h18;   // enables, bank 1 at +4
   localparam int OFS_CTRL = 'h20;
   localparam int OFS_BASE = 'h24;
   localparam int OFS_WIN  = 'h28;
   localparam int OFS_PRIO = 'h30;   // priority words, stride 4
   localparam int BANK_STRIDE = 4;
endpackage

// File: rtl/intc_src_pend.sv
module intc_src_pend #(
   parameter int NUM_SRC    = 64,
   parameter int PRIO_W     = 3,
   parameter int FIQ_LEVELS = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_SRC-1:0]             src_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   input  logic [NUM_SRC-1:0]             clr_fiq_i,
   input  logic [NUM_SRC-1:0]             clr_irq_i,
   output logic [NUM_SRC-1:0]             fiq_pend_o,
   output logic [NUM_SRC-1:0]             irq_pend_o
);
   for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
      logic prev_q;
      logic rise;
      logic to_fiq;

      assign rise   = src_i[n] & ~prev_q;
      assign to_fiq = (prio_i[n] < PRIO_W'(FIQ_LEVELS));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q        <= 1'b0;
            fiq_pend_o[n] <= 1'b0;
            irq_pend_o[n] <= 1'b0;
         end else begin
            prev_q        <= src_i[n];
            // a fresh edge wins over a coincident clear
            fiq_pend_o[n] <= (fiq_pend_o[n] & ~clr_fiq_i[n]) | (rise &  to_fiq);
            irq_pend_o[n] <= (irq_pend_o[n] & ~clr_irq_i[n]) | (rise & ~to_fiq);
         end
      end
   end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 3,
   parameter int IDX_W   = 7
) (
   input  logic [NUM_SRC-1:0]             cand_i,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
   output logic [IDX_W-1:0]               win_idx_o
);
   logic [PRIO_W-1:0] best_p;
   logic              found;

   always_comb begin
      win_idx_o = '1;
      best_p    = '1;
      found     = 1'b0;
      for (int n = 0; n < NUM_SRC; n++) begin
         // strict compare keeps the lowest index on ties
         if (cand_i[n] && (!found || (prio_i[n] < best_p))) begin
            found     = 1'b1;
            best_p    = prio_i[n];
            win_idx_o = IDX_W'(n);
         end
      end
   end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int BANK_W  = 32,
   parameter int PRIO_W  = 3,
   parameter int SLOT_W  = 4,
   parameter int ADDR_W  = 8,
   parameter int IDX_W   = 7
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_i,
   input  logic                           rd_i,
   input  logic [ADDR_W-1:0]              addr_i,
   input  logic [BANK_W-1:0]              wdata_i,
   input  logic [NUM_SRC-1:0]             fiq_pend_i,
   input  logic [NUM_SRC-1:0]             irq_pend_i,
   input  logic [IDX_W-1:0]               win_idx_i,
   output logic [NUM_SRC-1:0]             en_o,
   output logic [NUM_SRC-1:0][PRIO_W-1:0] prio_o,
   output logic [NUM_SRC-1:0]             clr_fiq_o,
   output logic [NUM_SRC-1:0]             clr_irq_o,
   output logic [BANK_W-1:0]              rdata_o
);
   localparam int NUM_BANK = NUM_SRC / BANK_W;
   localparam int SPW      = BANK_W / SLOT_W;
   localparam int NUM_PRW  = NUM_SRC / SPW;

   logic [BANK_W-1:0] ctrl_q;
   logic [BANK_W-1:0] base_q;
   logic [BANK_W-1:0] rd_next;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   always_comb begin
      clr_fiq_o = '0;
      clr_irq_o = '0;
      for (int b = 0; b < NUM_BANK; b++) begin
         if (wr_i && hit(addr_i, OFS_FIQ0 + BANK_STRIDE*b))
            clr_fiq_o[b*BANK_W +: BANK_W] = wdata_i;
         if (wr_i && hit(addr_i, OFS_IRQ0 + BANK_STRIDE*b))
            clr_irq_o[b*BANK_W +: BANK_W] = wdata_i;
      end
   end

   always_comb begin
      rd_next = '0;
      for (int b = 0; b < NUM_BANK; b++) begin
         if (hit(addr_i, OFS_FIQ0 + BANK_STRIDE*b)) rd_next = fiq_pend_i[b*BANK_W +: BANK_W];
         if (hit(addr_i, OFS_IRQ0 + BANK_STRIDE*b)) rd_next = irq_pend_i[b*BANK_W +: BANK_W];
         if (hit(addr_i, OFS_EN0  + BANK_STRIDE*b)) rd_next = en_o[b*BANK_W +: BANK_W];
      end
      if (hit(addr_i, OFS_CTRL)) rd_next = ctrl_q;
      if (hit(addr_i, OFS_BASE)) rd_next = base_q;
      if (hit(addr_i, OFS_WIN))  rd_next = BANK_W'(win_idx_i);
      for (int k = 0; k < NUM_PRW; k++) begin
         if (hit(addr_i, OFS_PRIO + 4*k)) begin
            for (int j = 0; j < SPW; j++)
               rd_next[j*SLOT_W +: PRIO_W] = prio_o[k*SPW + j];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o    <= '0;
         prio_o  <= '1;
         ctrl_q  <= '0;
         base_q  <= '0;
         rdata_o <= '0;
      end else begin
         if (wr_i) begin
            for (int b = 0; b < NUM_BANK; b++) begin
               if (hit(addr_i, OFS_EN0 + BANK_STRIDE*b))
                  en_o[b*BANK_W +: BANK_W] <= wdata_i;
            end
            if (hit(addr_i, OFS_CTRL)) ctrl_q <= wdata_i;
            if (hit(addr_i, OFS_BASE)) base_q <= wdata_i;
            for (int k = 0; k < NUM_PRW; k++) begin
               if (hit(addr_i, OFS_PRIO + 4*k)) begin
                  for (int j = 0; j < SPW; j++)
                     prio_o[k*SPW + j] <= wdata_i[j*SLOT_W +: PRIO_W];
               end
            end
         end
         if (rd_i) rdata_o <= rd_next;
      end
   end
endmodule

// File: rtl/intc_prio_router.sv
module intc_prio_router #(
   parameter int NUM_SRC    = 64,
   parameter int BANK_W     = 32,
   parameter int PRIO_W     = 3,
   parameter int SLOT_W     = 4,
   parameter int FIQ_LEVELS = 2,
   parameter int ADDR_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               bus_wr_i,
   input  logic               bus_rd_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [BANK_W-1:0]  bus_wdata_i,
   output logic [BANK_W-1:0]  bus_rdata_o,
   output logic               fiq_o,
   output logic               irq_o
);
   localparam int IDX_W = $clog2(NUM_SRC) + 1;

   if (BANK_W != 32) begin : g_bad_bank
      $error("BANK_W must be 32");
   end
   if (NUM_SRC != 2 * BANK_W) begin : g_bad_src
      $error("register map holds exactly two banks");
   end
   if (PRIO_W < 1 || PRIO_W >= SLOT_W || BANK_W % SLOT_W != 0) begin : g_bad_slot
      $error("priority field must fit inside its slot");
   end
   if (FIQ_LEVELS < 1 || FIQ_LEVELS >= (1 << PRIO_W)) begin : g_bad_fiq
      $error("FIQ_LEVELS out of range");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must cover the map");
   end

   logic [NUM_SRC-1:0]             fiq_pend_w;
   logic [NUM_SRC-1:0]             irq_pend_w;
   logic [NUM_SRC-1:0]             en_w;
   logic [NUM_SRC-1:0]             clr_fiq_w;
   logic [NUM_SRC-1:0]             clr_irq_w;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_w;
   logic [IDX_W-1:0]               win_idx_w;

   intc_regs #(
      .NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .PRIO_W(PRIO_W),
      .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr_i),
      .rd_i       (bus_rd_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .fiq_pend_i (fiq_pend_w),
      .irq_pend_i (irq_pend_w),
      .win_idx_i  (win_idx_w),
      .en_o       (en_w),
      .prio_o     (prio_w),
      .clr_fiq_o  (clr_fiq_w),
      .clr_irq_o  (clr_irq_w),
      .rdata_o    (bus_rdata_o)
   );

   intc_src_pend #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .FIQ_LEVELS(FIQ_LEVELS)
   ) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i),
      .prio_i     (prio_w),
      .clr_fiq_i  (clr_fiq_w),
      .clr_irq_i  (clr_irq_w),
      .fiq_pend_o (fiq_pend_w),
      .irq_pend_o (irq_pend_w)
   );

   intc_arb #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)
   ) u_arb (
      .cand_i    (irq_pend_w & en_w),
      .prio_i    (prio_w),
      .win_idx_o (win_idx_w)
   );

   assign fiq_o = |(fiq_pend_w & en_w);
   assign irq_o = |(irq_pend_w & en_w);
endmodule

// File: rtl/intc_prio_router_chk.sv
module intc_prio_router_chk #(
   parameter int NUM_SRC    = 64,
   parameter int BANK_W     = 32,
   parameter int PRIO_W     = 3,
   parameter int FIQ_LEVELS = 2,
   parameter int ADDR_W     = 8,
   parameter int IDX_W      = 7
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [NUM_SRC-1:0]             src_i,
   input logic                           bus_wr_i,
   input logic                           bus_rd_i,
   input logic [ADDR_W-1:0]              bus_addr_i,
   input logic [BANK_W-1:0]              bus_rdata_o,
   input logic                           fiq_o,
   input logic                           irq_o,
   input logic [NUM_SRC-1:0]             en,
   input logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
   input logic [IDX_W-1:0]               win_idx
);
   logic [NUM_SRC-1:0] fast_map;

   always_comb begin
      for (int n = 0; n < NUM_SRC; n++)
         fast_map[n] = (prio[n] < PRIO_W'(FIQ_LEVELS));
   end

   // R4
   en_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> (!fiq_o && !irq_o));

   // R5
   fiq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(src_i & ~$past(src_i) & en & fast_map)) && !bus_wr_i) |=> fiq_o);

   // R6
   irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|(src_i & ~$past(src_i) & en & ~fast_map)) && !bus_wr_i) |=> irq_o);

   // R8
   win_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o |-> (win_idx == '1));

   // R8
   win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (win_idx < IDX_W'(NUM_SRC)));

   // R10
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i >= ADDR_W'('h50)) |=> (bus_rdata_o == '0));

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

bind intc_prio_router intc_prio_router_chk #(
   .NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .PRIO_W(PRIO_W),
   .FIQ_LEVELS(FIQ_LEVELS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .src_i       (src_i),
   .bus_wr_i    (bus_wr_i),
   .bus_rd_i    (bus_rd_i),
   .bus_addr_i  (bus_addr_i),
   .bus_rdata_o (bus_rdata_o),
   .fiq_o       (fiq_o),
   .irq_o       (irq_o),
   .en          (en_w),
   .prio        (prio_w),
   .win_idx     (win_idx_w)
);

// File: tb/tb_intc_prio_router.sv
`timescale 1ns/1ps
module tb_intc_prio_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic        wr = 1'b0;
   logic        rd = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        fiq;
   logic        irq;

   int total = 0;
   int bad = 0;
   logic [31:0] v;

   always #10 clk = ~clk;

   intc_prio_router dut (
      .clk(clk), .rst_n(rst_n), .src_i(src),
      .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
      .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a; rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic pulse(input int n);
      @(negedge clk);
      src[n] = 1'b1;
      @(negedge clk);
      src[n] = 1'b0;
   endtask

   task automatic t_reset();
      bus_read(8'h00, v); chk("R1", "fast0", v, 32'h0);
      bus_read(8'h04, v); chk("R1", "fast1", v, 32'h0);
      bus_read(8'h08, v); chk("R1", "norm0", v, 32'h0);
      bus_read(8'h0C, v); chk("R1", "norm1", v, 32'h0);
      bus_read(8'h18, v); chk("R1", "en0", v, 32'h0);
      bus_read(8'h1C, v); chk("R1", "en1", v, 32'h0);
      bus_read(8'h20, v); chk("R1", "ctrl", v, 32'h0);
      bus_read(8'h24, v); chk("R1", "base", v, 32'h0);
      bus_read(8'h30, v); chk("R1", "prio0", v, 32'h77777777);
      bus_read(8'h4C, v); chk("R1", "prio7", v, 32'h77777777);
      bus_read(8'h28, v); chk("R1", "winner", v, 32'h7F);
      chk("R1", "fiq_o", {31'b0, fiq}, 32'h0);
      chk("R1", "irq_o", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_route();
      bus_write(8'h30, 32'h77777730);
      bus_write(8'h18, 32'hFFFFFFFF);
      pulse(0);
      chk("R5", "fiq_o after fast edge", {31'b0, fiq}, 32'h1);
      chk("R6", "irq_o idle", {31'b0, irq}, 32'h0);
      bus_read(8'h00, v); chk("R2", "fast0 src0", v, 32'h1);
      pulse(1);
      chk("R6", "irq_o after normal edge", {31'b0, irq}, 32'h1);
      bus_read(8'h08, v); chk("R2", "norm0 src1", v, 32'h2);
      pulse(40);
      bus_read(8'h0C, v); chk("R2", "norm1 src40", v, 32'h100);
      bus_read(8'h28, v); chk("R8", "winner src1", v, 32'h1);
      bus_write(8'h08, 32'h2);
      bus_read(8'h08, v); chk("R3", "norm0 cleared", v, 32'h0);
      chk("R4", "disabled src40 quiet", {31'b0, irq}, 32'h0);
      bus_read(8'h28, v); chk("R8", "winner none", v, 32'h7F);
      bus_read(8'h0C, v); chk("R4", "disabled still pending", v, 32'h100);
      bus_write(8'h1C, 32'h100);
      chk("R4", "irq_o on enable", {31'b0, irq}, 32'h1);
      bus_read(8'h1C, v); chk("R4", "en1 readback", v, 32'h100);
      bus_read(8'h28, v); chk("R8", "winner src40", v, 32'd40);
      bus_write(8'h00, 32'hFFFFFFFE);
      bus_read(8'h00, v); chk("R3", "zero bit kept", v, 32'h1);
      bus_write(8'h00, 32'hFFFFFFFF);
      bus_read(8'h00, v); chk("R3", "bank clear", v, 32'h0);
      chk("R5", "fiq_o after clear", {31'b0, fiq}, 32'h0);
      bus_write(8'h0C, 32'hFFFFFFFF);
      chk("R6", "irq_o after clear", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_level();
      @(negedge clk); src[2] = 1'b1;
      @(negedge clk);
      bus_read(8'h08, v); chk("R2", "level edge", v, 32'h4);
      bus_write(8'h08, 32'h4);
      repeat (3) @(negedge clk);
      bus_read(8'h08, v); chk("R2", "held level no reset", v, 32'h0);
      chk("R6", "irq_o held level", {31'b0, irq}, 32'h0);
      @(negedge clk); src[2] = 1'b0;
   endtask

   task automatic t_coincide();
      @(negedge clk);
      addr = 8'h08; wdata = 32'h8; wr = 1'b1; src[3] = 1'b1;
      @(negedge clk);
      wr = 1'b0; src[3] = 1'b0;
      bus_read(8'h08, v); chk("R3", "edge beats clear", v, 32'h8);
      bus_write(8'h08, 32'h8);
      bus_read(8'h08, v); chk("R3", "later clear", v, 32'h0);
   endtask

   task automatic t_prio_layout();
      bus_write(8'h4C, 32'hFEDCBA98);
      bus_read(8'h4C, v); chk("R7", "slot low bits", v, 32'h76543210);
      bus_write(8'h1C, 32'hFFFFFFFF);
      pulse(57);
      bus_read(8'h04, v); chk("R7", "src57 prio1 fast", v, 32'h02000000);
      chk("R5", "fiq_o bank1", {31'b0, fiq}, 32'h1);
      pulse(63);
      bus_read(8'h0C, v); chk("R7", "src63 prio7 normal", v, 32'h80000000);
      bus_read(8'h28, v); chk("R8", "winner src63", v, 32'd63);
      bus_write(8'h04, 32'hFFFFFFFF);
      bus_write(8'h0C, 32'hFFFFFFFF);
   endtask

   task automatic t_winner();
      for (int k = 0; k < 8; k++) bus_write(8'(8'h30 + 4*k), 32'h77777777);
      bus_write(8'h30, 32'h77477770);
      bus_write(8'h34, 32'h77777477);
      bus_write(8'h38, 32'h77727777);
      bus_write(8'h48, 32'h77777677);
      bus_write(8'h18, 32'hFFEFFFFF);
      bus_write(8'h1C, 32'hFFFFFFFF);
      pulse(5); pulse(10); pulse(50);
      bus_read(8'h28, v); chk("R8", "tie lowest index", v, 32'd5);
      bus_write(8'h08, 32'h20);
      bus_read(8'h28, v); chk("R8", "next winner", v, 32'd10);
      pulse(20);
      bus_read(8'h28, v); chk("R8", "disabled ignored", v, 32'd10);
      bus_write(8'h18, 32'hFFFFFFFF);
      bus_read(8'h28, v); chk("R8", "stronger prio wins", v, 32'd20);
      pulse(0);
      bus_read(8'h28, v); chk("R8", "fast source ignored", v, 32'd20);
      bus_write(8'h08, 32'hFFFFFFFF);
      bus_write(8'h0C, 32'hFFFFFFFF);
      bus_read(8'h28, v); chk("R8", "none left", v, 32'h7F);
      chk("R6", "irq_o none", {31'b0, irq}, 32'h0);
      chk("R5", "fiq_o src0", {31'b0, fiq}, 32'h1);
      bus_write(8'h28, 32'h0);
      bus_read(8'h28, v); chk("R8", "write ignored", v, 32'h7F);
      bus_write(8'h00, 32'hFFFFFFFF);
   endtask

   task automatic t_storage();
      bus_write(8'h20, 32'hA5A55A5A);
      bus_write(8'h24, 32'h12345678);
      bus_read(8'h20, v); chk("R9", "ctrl", v, 32'hA5A55A5A);
      bus_read(8'h24, v); chk("R9", "base", v, 32'h12345678);
   endtask

   task automatic t_unmapped();
      bus_write(8'h18, 32'h0000F00F);
      bus_write(8'h10, 32'hFFFFFFFF);
      bus_write(8'h2C, 32'hFFFFFFFF);
      bus_write(8'h19, 32'hFFFFFFFF);
      bus_write(8'h60, 32'hFFFFFFFF);
      bus_read(8'h18, v); chk("R10", "en0 untouched", v, 32'h0000F00F);
      bus_read(8'h20, v); chk("R10", "ctrl untouched", v, 32'hA5A55A5A);
      bus_read(8'h10, v); chk("R10", "read 0x10", v, 32'h0);
      bus_read(8'h2C, v); chk("R10", "read 0x2C", v, 32'h0);
      bus_read(8'h19, v); chk("R10", "read 0x19", v, 32'h0);
      bus_read(8'h60, v); chk("R10", "read 0x60", v, 32'h0);
   endtask

   task automatic t_rd_hold();
      bus_read(8'h20, v); chk("R11", "read ctrl", v, 32'hA5A55A5A);
      bus_write(8'h20, 32'h0F0F0F0F);
      @(negedge clk);
      chk("R11", "rdata held", rdata, 32'hA5A55A5A);
      bus_read(8'h20, v); chk("R11", "write visible next read", v, 32'h0F0F0F0F);
   endtask

   initial begin
      #(20 * 100000);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_route();
      t_level();
      t_coincide();
      t_prio_layout();
      t_winner();
      t_storage();
      t_unmapped();
      t_rd_hold();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule